// File: doc/BRIEF.md
# Regulator Soft-Start and Enable Sequencer

This block sequences the start-up and shut-down of a step-down regulator from comparator flags that are already digitized and synchronous to the block clock. The bias-supply power-on detect has hysteresis. One flag is high above the rising threshold and another is high above the lower falling threshold. The enable input has a high and a low threshold, and the band between them holds the previous decision. Once the supply is good and the converter is enabled, the block holds a sample strobe for the current-limit setting open for a window. The window length is a linear function of a programmed code. Only after the window closes does the block start the reference ramp.

The ramp is a digital code that climbs one step every `STEP_DIV` clocks from zero to `FINAL_CODE`. A one-cycle done pulse marks its arrival. If the output already holds charge, a feedback-versus-ramp comparator reports when the ramp has caught up with the feedback level. Switching stays off until that happens, so the converter never pulls a pre-biased output down. An under-voltage fault after soft-start, or a shutdown through the enable input, moves the block to a soft-stop state. In that state only the discharge switch is on. A fault is latched until the enable input has been seen low and then high again. Losing the supply-good detect at any time returns the block to idle with every output off.

Top module: `ss_sequencer`

## Requirements
- R1: The supply-good state sets when `vcc_above_rise` is 1 and clears only when `vcc_above_fall` is 0. With `vcc_above_fall`=1 and `vcc_above_rise`=0 it keeps its value, so start-up needs the rising flag, and a running converter keeps running when only the rising flag drops.
- R2: The enable state sets when `en_above_on`=1 and clears when `en_below_off`=1. It holds when both are 0. A converter keeps running in the middle band, and a shut-down converter stays shut down in the middle band.
- R3: After start, `ocset_sample` is high for exactly `code*OC_SCALE + OC_BASE` clock cycles, where `code` is `ocset_code`. During the window `ramp_code` is 0 and `sw_en` is 0.
- R4: In the cycle after the window closes, `ramp_code` is 0. It then rises by exactly 1 every `STEP_DIV` cycles, reaches `FINAL_CODE` `FINAL_CODE*STEP_DIV` cycles after the window closes, and never exceeds `FINAL_CODE`.
- R5: `ss_done` is high for exactly one cycle, the first cycle in which `ramp_code` equals `FINAL_CODE`.
- R6: During and after the ramp, `sw_en` is 1 from the cycle after the first cycle in which `fb_ge_ramp` is 1, and 0 before that.
- R7: `uv_fault` has no effect while ramping. After the ramp, `uv_fault`=1 makes the next cycle show `dischg_en`=1, `sw_en`=0 and `ramp_code`=0.
- R8: Two cycles after the enable low flag is applied, `dischg_en` is 1 and `sw_en` is 0. A discharge state is left, through a new sample window, only after the enable state has been seen cleared and then set again. Clearing `uv_fault` alone does not leave it.
- R9: Two cycles after `vcc_above_fall` drops to 0, `sw_en`, `dischg_en`, `ocset_sample` and `ramp_code` are all 0, whatever the previous state.
- R10: During and just after reset, every output is 0.
- R11: `sw_en` and `dischg_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_rise | input | 1 | Bias supply above rising detect threshold |
| vcc_above_fall | input | 1 | Bias supply above falling detect threshold |
| en_above_on | input | 1 | Enable input above turn-on threshold |
| en_below_off | input | 1 | Enable input below shutdown threshold |
| uv_fault | input | 1 | Debounced output under-voltage flag |
| fb_ge_ramp | input | 1 | Ramp reference at or above the feedback level |
| ocset_code | input | OC_W | Current-limit setting code that sets the sample window |
| ramp_code | output | RAMP_W | Digital soft-start reference code |
| ocset_sample | output | 1 | Current-limit sample-and-hold strobe |
| sw_en | output | 1 | Power stage switching enable |
| dischg_en | output | 1 | Soft-stop discharge switch enable |
| ss_done | output | 1 | One-cycle soft-start completion pulse |

## Verification
The embedded properties assume that every comparator flag is already debounced and synchronous to `clk`. They also assume the flags stay physically consistent: the enable on and off flags are never high together, and the supply rising flag is only high while the falling flag is high. The stimulus keeps to these rules. It draws random window codes, feedback levels and fault timing from `$urandom` with a fixed seed, and it never raises both enable flags or the rising supply flag without the falling one. The feedback-versus-ramp flag is formed in the bench from the ramp code and a chosen feedback level. It therefore behaves like the real comparator and changes only when the ramp moves.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_SAMPLE = 3'd1,
      SQ_RAMP   = 3'd2,
      SQ_RUN    = 3'd3,
      SQ_STOP   = 3'd4
   } seq_state_t;

   function automatic int win_max(input int code_w, input int scale, input int base);
      return ((1 << code_w) - 1) * scale + base;
   endfunction

endpackage

// File: rtl/ss_hyst_latch.sv
module ss_hyst_latch #(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   generate
      if (CLEAR_WINS) begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o <= 1'b0;
            else if (clr_i) q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
            else if (clr_i) q_o <= 1'b0;
         end
      end
   endgenerate

   // Holds its value when neither input is active (R1, R2)
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(set_i) && !$past(clr_i)) |-> $stable(q_o));

endmodule

// File: rtl/ss_win_timer.sv
module ss_win_timer #(
   parameter int CODE_W = 6,
   parameter int SCALE  = 4,
   parameter int BASE   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              zero_o
);
   import ss_seq_pkg::*;

   localparam int MAX_WIN = win_max(CODE_W, SCALE, BASE);
   localparam int WIN_W   = $clog2(MAX_WIN + 1);

   generate
      if (SCALE < 1) begin : g_bad_scale
         $error("ss_win_timer: SCALE must be at least 1");
      end
      if (BASE < 1) begin : g_bad_base
         $error("ss_win_timer: BASE must be at least 1");
      end
   endgenerate

   logic [WIN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= WIN_W'(int'(code_i) * SCALE + BASE - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // Counter never loads beyond the longest legal window (R3)
   assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < MAX_WIN);

   // Without a load the counter only moves downward (R3)
   assert_win_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_i) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
   parameter int FINAL_CODE = 200,
   parameter int STEP_DIV   = 4,
   parameter int RAMP_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en_i,
   input  logic              keep_i,
   output logic [RAMP_W-1:0] ramp_o,
   output logic              last_o
);

   generate
      if (FINAL_CODE < 1 || FINAL_CODE >= (1 << RAMP_W)) begin : g_bad_final
         $error("ss_ramp_gen: FINAL_CODE must fit RAMP_W and be nonzero");
      end
      if (STEP_DIV < 1) begin : g_bad_div
         $error("ss_ramp_gen: STEP_DIV must be at least 1");
      end
   endgenerate

   logic tick;

   generate
      if (STEP_DIV == 1) begin : g_no_div
         assign tick = step_en_i;
      end else begin : g_div
         localparam int DIV_W = $clog2(STEP_DIV);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                div_q <= '0;
            else if (!step_en_i)                       div_q <= '0;
            else if (div_q == DIV_W'(STEP_DIV - 1))    div_q <= '0;
            else                                       div_q <= div_q + 1'b1;
         end
         assign tick = step_en_i && (div_q == DIV_W'(STEP_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        ramp_o <= '0;
      else if (!keep_i)                                  ramp_o <= '0;
      else if (tick && ramp_o != RAMP_W'(FINAL_CODE))    ramp_o <= ramp_o + 1'b1;
   end

   assign last_o = tick && (ramp_o == RAMP_W'(FINAL_CODE - 1));

   // Ramp never overshoots the target code (R4)
   assert_ramp_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ramp_o) <= FINAL_CODE);

   // Ramp moves only by a single step up or a clear to zero (R4)
   assert_ramp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_o != $past(ramp_o)) |-> (ramp_o == $past(ramp_o) + 1'b1 || ramp_o == '0));

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic por_i,
   input  logic en_i,
   input  logic uv_i,
   input  logic fb_ge_ramp_i,
   input  logic win_zero_i,
   input  logic ramp_last_i,
   output logic timer_load_o,
   output logic step_en_o,
   output logic ramp_keep_o,
   output logic ocset_sample_o,
   output logic sw_en_o,
   output logic dischg_en_o,
   output logic ss_done_o
);
   import ss_seq_pkg::*;

   seq_state_t state_q, state_d;
   logic       tracked_q;
   logic       seen_low_q;
   logic       active_now, active_next;

   always_comb begin
      state_d = state_q;
      if (!por_i) begin
         state_d = SQ_IDLE;
      end else begin
         unique case (state_q)
            SQ_IDLE:   if (en_i) state_d = SQ_SAMPLE;
            SQ_SAMPLE: if (!en_i) state_d = SQ_STOP;
                       else if (win_zero_i) state_d = SQ_RAMP;
            SQ_RAMP:   if (!en_i) state_d = SQ_STOP;
                       else if (ramp_last_i) state_d = SQ_RUN;
            SQ_RUN:    if (!en_i || uv_i) state_d = SQ_STOP;
            SQ_STOP:   if (en_i && seen_low_q) state_d = SQ_SAMPLE;
            default:   state_d = SQ_IDLE;
         endcase
      end
   end

   assign active_now  = (state_q == SQ_RAMP) || (state_q == SQ_RUN);
   assign active_next = (state_d == SQ_RAMP) || (state_d == SQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         tracked_q  <= 1'b0;
         seen_low_q <= 1'b0;
         ss_done_o  <= 1'b0;
      end else begin
         state_q    <= state_d;
         tracked_q  <= active_next && (tracked_q || (active_now && fb_ge_ramp_i));
         seen_low_q <= (state_q == SQ_STOP) && (seen_low_q || !en_i);
         ss_done_o  <= (state_q == SQ_RAMP) && (state_d == SQ_RUN);
      end
   end

   assign timer_load_o   = (state_d == SQ_SAMPLE) && (state_q != SQ_SAMPLE);
   assign step_en_o      = (state_q == SQ_RAMP);
   assign ramp_keep_o    = active_next;
   assign ocset_sample_o = (state_q == SQ_SAMPLE);
   assign sw_en_o        = tracked_q && active_now;
   assign dischg_en_o    = (state_q == SQ_STOP);

   // Completion flag is a single-cycle pulse (R5)
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done_o |=> !ss_done_o);

   // A latched stop is left only through a fresh sample window (R8)
   assert_stop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dischg_en_o && por_i) |=> (dischg_en_o || ocset_sample_o));

   // Switching never starts while feedback has not been reached (R6)
   assert_prebias_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en_o) |-> $past(fb_ge_ramp_i));

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer #(
   parameter int OC_W       = 6,
   parameter int OC_SCALE   = 4,
   parameter int OC_BASE    = 10,
   parameter int FINAL_CODE = 200,
   parameter int STEP_DIV   = 4,
   parameter int RAMP_W     = $clog2(FINAL_CODE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vcc_above_rise,
   input  logic              vcc_above_fall,
   input  logic              en_above_on,
   input  logic              en_below_off,
   input  logic              uv_fault,
   input  logic              fb_ge_ramp,
   input  logic [OC_W-1:0]   ocset_code,
   output logic [RAMP_W-1:0] ramp_code,
   output logic              ocset_sample,
   output logic              sw_en,
   output logic              dischg_en,
   output logic              ss_done
);

   generate
      if (OC_W < 1) begin : g_bad_ocw
         $error("ss_sequencer: OC_W must be at least 1");
      end
   endgenerate

   logic por_q, en_q;
   logic win_zero, timer_load;
   logic step_en, ramp_keep, ramp_last;

   ss_hyst_latch #(.CLEAR_WINS(1'b1)) u_por (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (vcc_above_rise),
      .clr_i (!vcc_above_fall),
      .q_o   (por_q)
   );

   ss_hyst_latch #(.CLEAR_WINS(1'b1)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (en_above_on),
      .clr_i (en_below_off),
      .q_o   (en_q)
   );

   ss_win_timer #(.CODE_W(OC_W), .SCALE(OC_SCALE), .BASE(OC_BASE)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (timer_load),
      .code_i (ocset_code),
      .zero_o (win_zero)
   );

   ss_ramp_gen #(.FINAL_CODE(FINAL_CODE), .STEP_DIV(STEP_DIV), .RAMP_W(RAMP_W)) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en_i (step_en),
      .keep_i    (ramp_keep),
      .ramp_o    (ramp_code),
      .last_o    (ramp_last)
   );

   ss_seq_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .por_i          (por_q),
      .en_i           (en_q),
      .uv_i           (uv_fault),
      .fb_ge_ramp_i   (fb_ge_ramp),
      .win_zero_i     (win_zero),
      .ramp_last_i    (ramp_last),
      .timer_load_o   (timer_load),
      .step_en_o      (step_en),
      .ramp_keep_o    (ramp_keep),
      .ocset_sample_o (ocset_sample),
      .sw_en_o        (sw_en),
      .dischg_en_o    (dischg_en),
      .ss_done_o      (ss_done)
   );

   // Drive and discharge are mutually exclusive (R11)
   assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_en && dischg_en));

   // Sampling window keeps the ramp at zero and the stage off (R3)
   assert_sample_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ocset_sample |-> (ramp_code == '0 && !sw_en));

   // Lost supply detect forces everything off next cycle (R9)
   assert_por_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !por_q |=> (!sw_en && !dischg_en && !ocset_sample));

   // Done pulse coincides with the ramp at its target (R5)
   assert_done_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done |-> (int'(ramp_code) == FINAL_CODE));

endmodule

// File: tb/ss_sequencer_tb.sv
module ss_sequencer_tb;

   localparam int OC_W       = 6;
   localparam int OC_SCALE   = 4;
   localparam int OC_BASE    = 10;
   localparam int FINAL_CODE = 200;
   localparam int STEP_DIV   = 4;
   localparam int RAMP_W     = $clog2(FINAL_CODE + 1);
   localparam int RAMP_LEN   = FINAL_CODE * STEP_DIV;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vcc_above_rise = 1'b0;
   logic              vcc_above_fall = 1'b0;
   logic              en_above_on = 1'b0;
   logic              en_below_off = 1'b1;
   logic              uv_fault = 1'b0;
   logic              fb_ge_ramp;
   logic [OC_W-1:0]   ocset_code = '0;
   logic [RAMP_W-1:0] ramp_code;
   logic              ocset_sample, sw_en, dischg_en, ss_done;

   int fb_lvl = 0;
   int nvec = 0;
   int nfail = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   assign fb_ge_ramp = (int'(ramp_code) >= fb_lvl);

   ss_sequencer #(
      .OC_W(OC_W), .OC_SCALE(OC_SCALE), .OC_BASE(OC_BASE),
      .FINAL_CODE(FINAL_CODE), .STEP_DIV(STEP_DIV), .RAMP_W(RAMP_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .vcc_above_rise(vcc_above_rise), .vcc_above_fall(vcc_above_fall),
      .en_above_on(en_above_on), .en_below_off(en_below_off),
      .uv_fault(uv_fault), .fb_ge_ramp(fb_ge_ramp), .ocset_code(ocset_code),
      .ramp_code(ramp_code), .ocset_sample(ocset_sample), .sw_en(sw_en),
      .dischg_en(dischg_en), .ss_done(ss_done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         nfail = nfail + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      nvec = nvec + 1;
      if (act != exp) begin
         nfail = nfail + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_window(input int code);
      return code * OC_SCALE + OC_BASE;
   endfunction

   function automatic int exp_ramp(input int k);
      int r;
      r = (k - 1) / STEP_DIV;
      return (r > FINAL_CODE) ? FINAL_CODE : r;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   // Waits for a start, then checks window, ramp, prebias and done pulse
   task automatic run_startup(input int code, input int fb, input bit uv_mid);
      int t, w, bad;
      bit tr;
      ocset_code = OC_W'(code);
      fb_lvl = fb;
      t = 0;
      tick();
      while (!ocset_sample && t < 12) begin
         tick();
         t++;
      end
      chk("R3 window opens", int'(ocset_sample), 1);
      w = 0;
      bad = 0;
      while (ocset_sample && w < 4000) begin
         if (ramp_code != '0 || sw_en) bad++;
         w++;
         tick();
      end
      chk("R3 window length", w, exp_window(code));
      chk("R3 quiet during window", bad, 0);
      tr = 1'b0;
      for (int k = 1; k <= RAMP_LEN + 1; k++) begin
         chk("R4 ramp code", int'(ramp_code), exp_ramp(k));
         chk("R6 switching vs feedback", int'(sw_en), int'(tr));
         chk("R5 done pulse", int'(ss_done), int'(k == RAMP_LEN + 1));
         if (uv_mid && k == 5)  uv_fault = 1'b1;
         if (uv_mid && k == 12) uv_fault = 1'b0;
         if (exp_ramp(k) >= fb) tr = 1'b1;
         if (k <= RAMP_LEN) tick();
      end
      chk("R7 no discharge while ramping", int'(dischg_en), 0);
      tick();
      chk("R5 done drops", int'(ss_done), 0);
      chk("R4 ramp holds final", int'(ramp_code), FINAL_CODE);
      chk("R6 switching after reach", int'(sw_en), int'(tr));
   endtask

   task automatic en_cycle();
      en_above_on = 1'b0;
      en_below_off = 1'b1;
      tick();
      tick();
      chk("R8 discharge on shutdown", int'(dischg_en), 1);
      chk("R11 switching off in stop", int'(sw_en), 0);
      en_below_off = 1'b0;
      en_above_on = 1'b1;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20241);
      repeat (3) tick();
      chk("R10 reset ramp", int'(ramp_code), 0);
      chk("R10 reset sample", int'(ocset_sample), 0);
      chk("R10 reset sw", int'(sw_en), 0);
      chk("R10 reset dischg", int'(dischg_en), 0);
      rst_n = 1'b1;
      tick();
      chk("R10 after reset done", int'(ss_done), 0);

      // Falling threshold alone must not start the sequence
      en_below_off = 1'b0;
      en_above_on = 1'b1;
      vcc_above_fall = 1'b1;
      repeat (20) tick();
      chk("R1 no start below rising", int'(ocset_sample), 0);
      vcc_above_rise = 1'b1;
      tick();
      vcc_above_rise = 1'b0;
      run_startup(3, 0, 1'b0);
      chk("R1 supply state held", int'(sw_en), 1);

      // Enable in the middle band keeps running
      en_above_on = 1'b0;
      repeat (10) tick();
      chk("R2 middle band keeps running", int'(sw_en), 1);

      // Under-voltage after soft-start
      uv_fault = 1'b1;
      tick();
      chk("R7 discharge on fault", int'(dischg_en), 1);
      chk("R7 switching off on fault", int'(sw_en), 0);
      chk("R7 ramp cleared on fault", int'(ramp_code), 0);
      uv_fault = 1'b0;
      repeat (10) tick();
      chk("R8 fault stays latched", int'(dischg_en), 1);
      en_below_off = 1'b1;
      tick();
      tick();
      chk("R8 still discharging", int'(dischg_en), 1);
      en_below_off = 1'b0;
      en_above_on = 1'b1;
      run_startup(int'($urandom % 16), FINAL_CODE / 2, 1'b1);

      // Shutdown via enable, then middle band holds off
      en_above_on = 1'b0;
      en_below_off = 1'b1;
      tick();
      chk("R8 one cycle later still on", int'(sw_en), 1);
      tick();
      chk("R8 discharge after enable low", int'(dischg_en), 1);
      chk("R8 switching off after enable low", int'(sw_en), 0);
      en_below_off = 1'b0;
      repeat (5) tick();
      chk("R2 middle band stays off", int'(dischg_en), 1);
      chk("R2 middle band no sample", int'(ocset_sample), 0);
      en_above_on = 1'b1;
      run_startup(int'($urandom % 16), FINAL_CODE, 1'b0);

      // Supply detect loss while running
      vcc_above_fall = 1'b0;
      tick();
      tick();
      chk("R9 sw off", int'(sw_en), 0);
      chk("R9 dischg off", int'(dischg_en), 0);
      chk("R9 sample off", int'(ocset_sample), 0);
      chk("R9 ramp cleared", int'(ramp_code), 0);
      vcc_above_fall = 1'b1;
      repeat (10) tick();
      chk("R1 needs rising flag again", int'(ocset_sample), 0);
      vcc_above_rise = 1'b1;
      run_startup(0, 0, 1'b0);

      // Supply detect loss during the sample window
      en_cycle();
      tick();
      while (!ocset_sample) tick();
      vcc_above_rise = 1'b0;
      vcc_above_fall = 1'b0;
      tick();
      tick();
      chk("R9 sample dropped", int'(ocset_sample), 0);
      chk("R9 no discharge", int'(dischg_en), 0);
      vcc_above_fall = 1'b1;
      vcc_above_rise = 1'b1;
      run_startup(int'($urandom % 16), int'($urandom % (FINAL_CODE + 1)), 1'b0);

      // Random start-ups
      for (int i = 0; i < 5; i++) begin
         en_cycle();
         run_startup(int'($urandom % 16), int'($urandom % (FINAL_CODE + 1)),
                     1'($urandom % 2));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule